// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit sits in the decode stage of a five-stage in-order pipeline and settles every control transfer there, one stage earlier than execute. It compares two register operands for equal and not-equal branches. It forms the PC-relative destination address and tells fetch whether to keep going sequentially or to jump to that address. Because the decision is made in decode, only one younger instruction has been fetched when a transfer is taken.

Two policies are selectable at run time. In the predict-not-taken policy, fetch always runs ahead sequentially. When a transfer turns out taken, the one instruction sitting in the IF/ID register is squashed into a bubble. In the delay-slot policy, the instruction after a transfer always completes and nothing is squashed. Unconditional jumps share the same redirect path with their condition forced true. A one-bit shadow flag remembers that the previous cycle redirected. The instruction that follows, either a squashed one or a delay slot, can then never redirect again.

Top module: `br_resolve_unit`

## Requirements
- R1: With kind code 1 (equal), the transfer is taken exactly when the two operands are bit-for-bit identical. With kind code 2 (not-equal), it is taken exactly when they differ in at least one bit.
- R2: Kind code 3 (jump) is taken whatever the operand values are.
- R3: `target_o` always equals `br_pc_i + 4 + 4 * sext(br_off_i)`, where the 16-bit offset is a two's complement number and the sum wraps modulo 2^32. For example, pc 40 with offset 7 gives 72.
- R4: In predict mode (`delay_mode_i` = 0), a taken transfer raises `pc_sel_o` and `ifid_flush_o` together in the same cycle, combinationally from the inputs.
- R5: A transfer that is not taken, including kind code 0 (no transfer), leaves `pc_sel_o` and `ifid_flush_o` both at 0, so it costs no bubble.
- R6: In delay-slot mode (`delay_mode_i` = 1), a taken transfer raises `pc_sel_o` and never raises `ifid_flush_o`.
- R7: When `id_valid_i` is 0, both `pc_sel_o` and `ifid_flush_o` stay 0.
- R8: In the cycle right after a cycle in which `pc_sel_o` was 1, the instruction in decode is ignored. `pc_sel_o` and `ifid_flush_o` stay 0 whatever its fields are.
- R9: An active-low `rst_n` clears the shadow flag and holds it clear, so the first instruction presented after reset is evaluated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_mode_i | input | 1 | 0: predict-not-taken with squash, 1: delay-slot policy |
| id_valid_i | input | 1 | The decode stage holds a real instruction |
| br_kind_i | input | 2 | 0 none, 1 equal, 2 not-equal, 3 jump |
| rs_val_i | input | 32 | First compared operand |
| rt_val_i | input | 32 | Second compared operand |
| br_pc_i | input | 32 | Address of the transfer instruction |
| br_off_i | input | 16 | Signed word offset |
| pc_sel_o | output | 1 | 1: fetch from `target_o`, 0: sequential fetch |
| target_o | output | 32 | PC-relative destination address |
| ifid_flush_o | output | 1 | Turn the IF/ID instruction into a bubble |

## Verification
The operand pairs include equal values, values that differ only in the lowest bit, values that differ only in the highest bit, and random pairs biased half toward equality. These separate a true full-width compare from one that ignores an end bit or swaps the sense of the two kinds. Offsets cover positive, negative, the two extremes and a PC that wraps past zero, which exposes a missing sign extension or a missing scale by four. Back-to-back transfers under both policies, toggling of the valid input, and a reset applied on top of a taken transfer show whether squash, delay-slot and shadow behaviour are kept apart.

// File: rtl/br_pkg.sv
`timescale 1ns/1ps
package br_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2,
    BK_JUMP = 2'd3
  } br_kind_e;
endpackage

// File: rtl/br_cond_eval.sv
`timescale 1ns/1ps
module br_cond_eval #(
  parameter int XLEN    = 32,
  parameter bit CMP_XOR = 1'b1
) (
  input  logic [1:0]      kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  import br_pkg::*;

  logic same;

  generate
    if (CMP_XOR) begin : g_xor
      logic [XLEN-1:0] diff;
      assign diff = a_i ^ b_i;
      assign same = ~|diff;
    end else begin : g_eq
      assign same = (a_i == b_i);
    end
  endgenerate

  always_comb begin
    case (br_kind_e'(kind_i))
      BK_EQ:   taken_o = same;
      BK_NE:   taken_o = ~same;
      BK_JUMP: taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_calc.sv
`timescale 1ns/1ps
module br_target_calc #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(4);

  function automatic logic [XLEN-1:0] widen_off(input logic [OFF_W-1:0] o);
    return {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [XLEN-1:0] to_bytes(input logic [XLEN-1:0] w);
    return {w[XLEN-3:0], 2'b00};
  endfunction

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] byte_off;

  assign seq_pc   = pc_i + SEQ_STEP;
  assign byte_off = to_bytes(widen_off(off_i));
  assign target_o = seq_pc + byte_off;
endmodule

// File: rtl/br_redirect_ctrl.sv
`timescale 1ns/1ps
module br_redirect_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic delay_mode_i,
  input  logic valid_i,
  input  logic taken_i,
  output logic fire_o,
  output logic flush_o,
  output logic shadow_o
);
  logic shadow_q;

  assign fire_o   = valid_i & taken_i & ~shadow_q;
  assign flush_o  = fire_o & ~delay_mode_i;
  assign shadow_o = shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else        shadow_q <= fire_o;
  end
endmodule

// File: rtl/br_resolve_unit.sv
`timescale 1ns/1ps
module br_resolve_unit #(
  parameter int XLEN    = 32,
  parameter int OFF_W   = 16,
  parameter bit CMP_XOR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             delay_mode_i,
  input  logic             id_valid_i,
  input  logic [1:0]       br_kind_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [XLEN-1:0]  br_pc_i,
  input  logic [OFF_W-1:0] br_off_i,
  output logic             pc_sel_o,
  output logic [XLEN-1:0]  target_o,
  output logic             ifid_flush_o
);
  logic cond_taken;
  logic redirect_fire;
  logic squash_fire;
  logic shadow_q;

  br_cond_eval #(.XLEN(XLEN), .CMP_XOR(CMP_XOR)) u_cond (
    .kind_i  (br_kind_i),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .taken_o (cond_taken)
  );

  br_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc_i     (br_pc_i),
    .off_i    (br_off_i),
    .target_o (target_o)
  );

  br_redirect_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .delay_mode_i (delay_mode_i),
    .valid_i      (id_valid_i),
    .taken_i      (cond_taken),
    .fire_o       (redirect_fire),
    .flush_o      (squash_fire),
    .shadow_o     (shadow_q)
  );

  assign pc_sel_o     = redirect_fire;
  assign ifid_flush_o = squash_fire;
endmodule

// File: rtl/br_resolve_chk.sv
`timescale 1ns/1ps
module br_resolve_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       delay_mode_i,
  input logic       id_valid_i,
  input logic [1:0] br_kind_i,
  input logic       pc_sel_o,
  input logic       ifid_flush_o,
  input logic       shadow_q
);
  // R4: a squash only ever accompanies a redirect
  p_flush_with_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush_o |-> pc_sel_o);

  // R6: delay-slot policy never squashes
  p_no_flush_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    delay_mode_i |-> !ifid_flush_o);

  // R7: empty decode slot is inert
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |-> (!pc_sel_o && !ifid_flush_o));

  // R8: no two redirects on consecutive cycles
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o |=> (!pc_sel_o && !ifid_flush_o));

  // R5: kind none never redirects
  p_none_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind_i == 2'd0) |-> !pc_sel_o);

  // R2: valid jump outside the shadow always redirects
  p_jump_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_i && br_kind_i == 2'd3 && !shadow_q) |-> pc_sel_o);
endmodule

bind br_resolve_unit br_resolve_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .delay_mode_i (delay_mode_i),
  .id_valid_i   (id_valid_i),
  .br_kind_i    (br_kind_i),
  .pc_sel_o     (pc_sel_o),
  .ifid_flush_o (ifid_flush_o),
  .shadow_q     (shadow_q)
);

// File: tb/br_resolve_unit_bench.sv
`timescale 1ns/1ps
module br_resolve_unit_bench;
  localparam real HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        delay_mode_i = 1'b0;
  logic        id_valid_i = 1'b0;
  logic [1:0]  br_kind_i = 2'd0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] br_pc_i = '0;
  logic [15:0] br_off_i = '0;
  logic        pc_sel_o;
  logic [31:0] target_o;
  logic        ifid_flush_o;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          sh = 1'b0;
  bit          done = 1'b0;

  br_resolve_unit u_br_resolve_unit (
    .clk(clk), .rst_n(rst_n), .delay_mode_i(delay_mode_i),
    .id_valid_i(id_valid_i), .br_kind_i(br_kind_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .br_pc_i(br_pc_i),
    .br_off_i(br_off_i), .pc_sel_o(pc_sel_o), .target_o(target_o),
    .ifid_flush_o(ifid_flush_o)
  );

  always #(HALF) clk = ~clk;

  function automatic bit model_taken(input logic [1:0] k, input logic [31:0] a,
                                     input logic [31:0] b);
    if (k == 2'd3) return 1'b1;
    if (k == 2'd1) return (a - b) == 32'd0;
    if (k == 2'd2) return (a - b) != 32'd0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_target(input logic [31:0] pc,
                                               input logic [15:0] off);
    logic signed [31:0] so;
    so = $signed(off);
    return pc + 32'd4 + (so * 32'sd4);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive one decode slot and check; caller positions on a negedge
  task automatic apply(input string tag, input bit mode, input bit vld,
                       input logic [1:0] k, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] pc,
                       input logic [15:0] off);
    bit fire;
    delay_mode_i = mode; id_valid_i = vld; br_kind_i = k;
    rs_val_i = a; rt_val_i = b; br_pc_i = pc; br_off_i = off;
    #1;
    fire = vld && !sh && model_taken(k, a, b);
    chk(tag, "pc_sel", {31'd0, pc_sel_o}, {31'd0, fire});
    chk(tag, "flush", {31'd0, ifid_flush_o}, {31'd0, fire && !mode});
    chk("R3", "target", target_o, model_target(pc, off));
    sh = fire;
  endtask

  task automatic cyc(input string tag, input bit mode, input bit vld,
                     input logic [1:0] k, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] pc,
                     input logic [15:0] off);
    @(negedge clk);
    apply(tag, mode, vld, k, a, b, pc, off);
  endtask

  function automatic string tag_for(input bit mode, input bit vld,
                                    input logic [1:0] k);
    if (!vld) return "R7";
    if (sh) return "R8";
    if (k == 2'd3) return "R2";
    if (k == 2'd0) return "R5";
    return mode ? "R6" : "R1";
  endfunction

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (2) @(negedge clk);
    #1;
    // reset state: outputs idle while in reset
    chk("R7", "reset pc_sel", {31'd0, pc_sel_o}, 32'd0);
    chk("R7", "reset flush", {31'd0, ifid_flush_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 worked example, equal operands taken in predict mode (R4)
    cyc("R4", 0, 1, 2'd1, 32'h55, 32'h55, 32'd40, 16'd7);
    chk("R3", "example 40+7", target_o, 32'd72);
    cyc("R8", 0, 1, 2'd3, 32'h0, 32'h1, 32'd44, 16'd3);      // squashed slot ignored
    cyc("R5", 0, 1, 2'd1, 32'h1, 32'h0, 32'd100, 16'd2);     // LSB differ, eq not taken
    cyc("R1", 0, 1, 2'd2, 32'h8000_0000, 32'h0, 32'd200, 16'hFFFF); // MSB differ, ne taken
    cyc("R8", 0, 1, 2'd2, 32'h1, 32'h2, 32'd204, 16'd0);
    cyc("R5", 0, 1, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd0, 16'h8000);
    cyc("R5", 0, 1, 2'd0, 32'h3, 32'h3, 32'hFFFF_FFFC, 16'd0); // wrap to 0
    chk("R3", "wrap", target_o, 32'd0);
    cyc("R6", 1, 1, 2'd1, 32'h7, 32'h7, 32'h1000, 16'h7FFF);  // delay slot, no flush
    cyc("R8", 1, 1, 2'd3, 32'h0, 32'h0, 32'h1004, 16'd1);     // delay slot transfer ignored
    cyc("R6", 1, 1, 2'd2, 32'h1, 32'h1, 32'h1008, 16'd1);     // not taken
    cyc("R7", 0, 0, 2'd3, 32'h0, 32'h0, 32'h2000, 16'd4);     // invalid jump
    cyc("R2", 0, 1, 2'd3, 32'h9, 32'h4, 32'h2000, 16'hFFFE);  // after invalid: evaluated

    // R9: reset lands on a taken transfer, first instruction after release fires
    cyc("R2", 0, 1, 2'd3, 32'h0, 32'h0, 32'h3000, 16'd5);
    #1 rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sh = 1'b0;
    apply("R9", 0, 1, 2'd3, 32'h0, 32'h0, 32'h3100, 16'd6);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit          m;
      bit          v;
      logic [1:0]  k;
      logic [31:0] a;
      logic [31:0] b;
      m = $urandom % 2;
      v = ($urandom % 8) != 0;
      k = 2'($urandom % 4);
      a = $urandom;
      b = ($urandom % 2) ? a : $urandom;
      cyc(tag_for(m, v, k), m, v, k, a, b, $urandom, 16'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule